// File: doc/BRIEF.md
# Set-Associative Read-Allocate Cache Controller

This block sits between a processor core and an external memory port and keeps recently read lines in a small unified store for instructions and data. With default parameters it holds 4 Kbytes as 64 sets of 4 ways, each line being four 32-bit words. The index and tag are cut straight from the virtual request address. Every access is looked up. A read that hits is answered from the store. A read that misses either fetches the whole line or performs one uncached word read, depending on the request's cacheable flag. Writes always go through to memory. A write changes the stored copy only when the line is already present, and it never brings a new line in.

The core side is a simple valid/ready request with a one-cycle response pulse. The memory side issues one request pulse per transaction. A line fill is flagged as a four-beat burst that starts at the line base and returns words in ascending order. A locked read is the first half of an indivisible read-then-write pair. It always goes to memory, and a lock output covers both halves. A level enable input and a flush pulse give the core control over the store.

Top module: `rac_cache`

## Requirements
- R1: Address fields: bits [3:2] select the word within a line, bits [9:4] select one of 64 sets, bits [31:10] form the tag; each set has 4 ways.
- R2: A non-locked read that hits while the cache is enabled raises `resp_valid` with the stored word on the cycle after acceptance and makes no memory request.
- R3: A non-locked cacheable read that misses while enabled issues one burst read (`mem_burst`=1) at the line base address (low 4 bits zero); once the fourth beat has arrived, the whole line hits.
- R4: A non-locked read that misses with `req_cacheable`=0 issues one single-word read (`mem_burst`=0) and installs nothing, so a repeat of it again goes to memory.
- R5: Lookup ignores `req_cacheable`: a non-cacheable read of a present line is served from the store without a memory request.
- R6: A read with `req_lock`=1 is always a single external read, even on a hit. `mem_lock` rises with its memory request and stays high until the next write completes, and that write updates a present line like any other.
- R7: Every write issues one single external write (`mem_write`=1) and gives a `resp_valid` pulse when `mem_ack` arrives. A write that hits replaces the addressed word in place. A write that misses installs nothing.
- R8: During a fill, the requested word is returned on `resp_valid` as soon as its beat arrives, which may be before the remaining beats are in.
- R9: Reset invalidates every line and leaves `req_ready`=1 with `resp_valid`, `mem_req` and `mem_lock` low. A one-cycle `flush` invalidates every line, including a line whose fill is under way.
- R10: `cache_en` takes effect one cycle after it changes and is treated as low out of reset. While disabled, every read is a single external read and writes leave the stored lines untouched.
- R11: A fill goes to a pseudo-random way taken from a free-running generator at the moment of the miss; the line just filled always hits next.
- R12: Only one memory transaction is outstanding at a time: `mem_req` is a one-cycle pulse and `req_ready` is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en | input | 1 | Cache enable level |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cacheable | input | 1 | Read miss may allocate |
| req_lock | input | 1 | Locked read/write pair qualifier |
| req_addr | input | ADDR_W | Virtual byte address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can accept a request |
| resp_valid | output | 1 | Read data or write completion pulse |
| resp_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | Memory transaction start pulse |
| mem_write | output | 1 | Memory transaction is a write |
| mem_burst | output | 1 | Memory read is a full-line burst |
| mem_lock | output | 1 | Locked sequence in progress |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rvalid | input | 1 | Memory read beat valid |
| mem_rdata | input | DATA_W | Memory read beat data |
| mem_ack | input | 1 | Memory write done |

## Verification
The main read and write paths are driven by a table of vectors. Each vector sets a different mix of hit or miss, cacheable or not, and locked or not, and the bench counts the memory transactions each one causes. A zero count separates a hit from a miss. A repeated uncached read separates allocation from no allocation. A write followed by a read tells an in-place update apart from memory-only data. Directed runs then fill one set past its way count, fetch word 0 against word 3 of a line to see early forwarding, and toggle the enable, flush and reset.

// File: rtl/rac_pkg.sv
package rac_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FILL   = 2'd1,
      ST_SINGLE = 2'd2,
      ST_WRITE  = 2'd3
   } rac_state_e;
endpackage

// File: rtl/rac_tag_store.sv
module rac_tag_store #(
   parameter int WAYS  = 4,
   parameter int SETS  = 64,
   parameter int TAG_W = 22,
   localparam int WAY_W = $clog2(WAYS),
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [IDX_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic             ins_en,
   input  logic [IDX_W-1:0] ins_set,
   input  logic [WAY_W-1:0] ins_way,
   input  logic [TAG_W-1:0] ins_tag,
   output logic             hit,
   output logic [WAY_W-1:0] hit_way
);
   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tags [SETS];
      logic [SETS-1:0]  vld;
      logic             wr_this;

      assign wr_this = ins_en && (ins_way == WAY_W'(w));

      always_ff @(posedge clk) begin
         if (wr_this) tags[ins_set] <= ins_tag;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       vld <= '0;
         else if (flush)   vld <= '0;
         else if (wr_this) vld[ins_set] <= 1'b1;
      end

      assign match[w] = vld[lk_set] && (tags[lk_set] == lk_tag);
   end

   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
   end
endmodule

// File: rtl/rac_data_store.sv
module rac_data_store #(
   parameter int WAYS   = 4,
   parameter int SETS   = 64,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int WAY_W = $clog2(WAYS),
   localparam int IDX_W = $clog2(SETS),
   localparam int OFF_W = $clog2(WORDS),
   localparam int AW    = WAY_W + IDX_W + OFF_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [IDX_W-1:0]  wr_set,
   input  logic [OFF_W-1:0]  wr_word,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [WAY_W-1:0]  rd_way,
   input  logic [IDX_W-1:0]  rd_set,
   input  logic [OFF_W-1:0]  rd_word,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] store [2**AW];

   always_ff @(posedge clk) begin
      if (wr_en) store[{wr_way, wr_set, wr_word}] <= wr_data;
   end

   assign rd_data = store[{rd_way, rd_set, rd_word}];
endmodule

// File: rtl/rac_victim.sv
module rac_victim #(
   parameter int WAY_W    = 2,
   parameter bit USE_LFSR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WAY_W-1:0] way
);
   if (USE_LFSR) begin : g_lfsr
      logic [7:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= 8'h5A;
         else        sr <= {sr[6:0], sr[7] ^ sr[5] ^ sr[4] ^ sr[3]};
      end
      assign way = sr[WAY_W-1:0];
   end else begin : g_count
      logic [WAY_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt <= '0;
         else        cnt <= cnt + 1'b1;
      end
      assign way = cnt;
   end
endmodule

// File: rtl/rac_cache.sv
module rac_cache
   import rac_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int WAYS     = 4,
   parameter int SETS     = 64,
   parameter int WORDS    = 4,
   parameter bit USE_LFSR = 1'b1,
   localparam int BYTE_W   = $clog2(DATA_W / 8),
   localparam int OFF_W    = $clog2(WORDS),
   localparam int IDX_W    = $clog2(SETS),
   localparam int WAY_W    = $clog2(WAYS),
   localparam int LINE_LSB = BYTE_W + OFF_W,
   localparam int TAG_W    = ADDR_W - LINE_LSB - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cache_en,
   input  logic              flush,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_cacheable,
   input  logic              req_lock,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_rdata,
   output logic              mem_req,
   output logic              mem_write,
   output logic              mem_burst,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (WORDS < 2 || (1 << OFF_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if (TAG_W < 1 || WAY_W > 8) begin : g_bad_geom
      $error("address too narrow for the geometry, or too many ways");
   end

   rac_state_e        state_q;
   logic              en_q, lock_q, kill_q;
   logic              resp_valid_q, mreq_q, mwrite_q, mburst_q;
   logic [DATA_W-1:0] resp_data_q, mwdata_q;
   logic [ADDR_W-1:0] maddr_q;
   logic [OFF_W-1:0]  beat_q, want_q;
   logic [IDX_W-1:0]  fill_set_q;
   logic [WAY_W-1:0]  fill_way_q;
   logic [TAG_W-1:0]  fill_tag_q;

   logic [OFF_W-1:0]  a_word;
   logic [IDX_W-1:0]  a_set;
   logic [TAG_W-1:0]  a_tag;
   logic              accept, hit, en_hit, ins_en, last_beat;
   logic [WAY_W-1:0]  hit_way, victim_way;
   logic [DATA_W-1:0] rd_data;
   logic              dw_en;
   logic [WAY_W-1:0]  dw_way;
   logic [IDX_W-1:0]  dw_set;
   logic [OFF_W-1:0]  dw_word;
   logic [DATA_W-1:0] dw_data;

   assign a_word    = req_addr[BYTE_W +: OFF_W];
   assign a_set     = req_addr[LINE_LSB +: IDX_W];
   assign a_tag     = req_addr[ADDR_W-1 -: TAG_W];
   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign en_hit    = en_q && hit;
   assign last_beat = (beat_q == OFF_W'(WORDS - 1));
   assign ins_en    = (state_q == ST_FILL) && mem_rvalid && last_beat && !kill_q && !flush;

   rac_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_set(a_set), .lk_tag(a_tag),
      .ins_en(ins_en), .ins_set(fill_set_q), .ins_way(fill_way_q), .ins_tag(fill_tag_q),
      .hit(hit), .hit_way(hit_way)
   );

   always_comb begin
      dw_en   = 1'b0;
      dw_way  = hit_way;
      dw_set  = a_set;
      dw_word = a_word;
      dw_data = req_wdata;
      if (state_q == ST_FILL) begin
         dw_en   = mem_rvalid;
         dw_way  = fill_way_q;
         dw_set  = fill_set_q;
         dw_word = beat_q;
         dw_data = mem_rdata;
      end else if (accept && req_write && en_hit) begin
         dw_en = 1'b1;
      end
   end

   rac_data_store #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
      .clk(clk), .wr_en(dw_en), .wr_way(dw_way), .wr_set(dw_set), .wr_word(dw_word),
      .wr_data(dw_data), .rd_way(hit_way), .rd_set(a_set), .rd_word(a_word), .rd_data(rd_data)
   );

   rac_victim #(.WAY_W(WAY_W), .USE_LFSR(USE_LFSR)) u_victim (
      .clk(clk), .rst_n(rst_n), .way(victim_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         en_q         <= 1'b0;
         lock_q       <= 1'b0;
         kill_q       <= 1'b0;
         resp_valid_q <= 1'b0;
         resp_data_q  <= '0;
         mreq_q       <= 1'b0;
         mwrite_q     <= 1'b0;
         mburst_q     <= 1'b0;
         maddr_q      <= '0;
         mwdata_q     <= '0;
         beat_q       <= '0;
         want_q       <= '0;
         fill_set_q   <= '0;
         fill_way_q   <= '0;
         fill_tag_q   <= '0;
      end else begin
         en_q         <= cache_en;
         resp_valid_q <= 1'b0;
         mreq_q       <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (req_write) begin
                     state_q  <= ST_WRITE;
                     mreq_q   <= 1'b1;
                     mwrite_q <= 1'b1;
                     mburst_q <= 1'b0;
                     maddr_q  <= req_addr;
                     mwdata_q <= req_wdata;
                     if (req_lock) lock_q <= 1'b1;
                  end else if (en_hit && !req_lock) begin
                     resp_valid_q <= 1'b1;
                     resp_data_q  <= rd_data;
                  end else if (en_q && req_cacheable && !req_lock) begin
                     state_q    <= ST_FILL;
                     mreq_q     <= 1'b1;
                     mwrite_q   <= 1'b0;
                     mburst_q   <= 1'b1;
                     maddr_q    <= {req_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
                     beat_q     <= '0;
                     want_q     <= a_word;
                     fill_set_q <= a_set;
                     fill_tag_q <= a_tag;
                     fill_way_q <= victim_way;
                     kill_q     <= 1'b0;
                  end else begin
                     state_q  <= ST_SINGLE;
                     mreq_q   <= 1'b1;
                     mwrite_q <= 1'b0;
                     mburst_q <= 1'b0;
                     maddr_q  <= req_addr;
                     if (req_lock) lock_q <= 1'b1;
                  end
               end
            end
            ST_FILL: begin
               if (flush) kill_q <= 1'b1;
               if (mem_rvalid) begin
                  if (beat_q == want_q) begin
                     resp_valid_q <= 1'b1;
                     resp_data_q  <= mem_rdata;
                  end
                  beat_q <= beat_q + 1'b1;
                  if (last_beat) state_q <= ST_IDLE;
               end
            end
            ST_SINGLE: begin
               if (mem_rvalid) begin
                  resp_valid_q <= 1'b1;
                  resp_data_q  <= mem_rdata;
                  state_q      <= ST_IDLE;
               end
            end
            ST_WRITE: begin
               if (mem_ack) begin
                  resp_valid_q <= 1'b1;
                  lock_q       <= 1'b0;
                  state_q      <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign resp_valid = resp_valid_q;
   assign resp_rdata = resp_data_q;
   assign mem_req    = mreq_q;
   assign mem_write  = mwrite_q;
   assign mem_burst  = mburst_q;
   assign mem_lock   = lock_q;
   assign mem_addr   = maddr_q;
   assign mem_wdata  = mwdata_q;
endmodule

// File: rtl/rac_cache_chk.sv
module rac_cache_chk #(
   parameter int ADDR_W   = 32,
   parameter int LINE_LSB = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_q,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic              req_cacheable,
   input logic              req_lock,
   input logic              hit,
   input logic              ins_en,
   input logic              resp_valid,
   input logic              mem_req,
   input logic              mem_write,
   input logic              mem_burst,
   input logic              mem_lock,
   input logic [ADDR_W-1:0] mem_addr
);
   logic acc_rd, acc_wr;
   assign acc_rd = req_valid && req_ready && !req_write;
   assign acc_wr = req_valid && req_ready && req_write;

   p_hit_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && !req_lock && en_q && hit) |=> (resp_valid && !mem_req));

   p_fill_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && !req_lock && en_q && !hit && req_cacheable) |=>
      (mem_req && mem_burst && !mem_write && (mem_addr[LINE_LSB-1:0] == '0)));

   p_uncached_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && !req_lock && en_q && !hit && !req_cacheable) |=>
      (mem_req && !mem_burst && !mem_write));

   p_install_burst_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> mem_burst);

   p_lock_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && req_lock) |=> (mem_req && !mem_burst && mem_lock));

   p_write_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr |=> (mem_req && mem_write && !mem_burst));

   p_disabled_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && !en_q) |=> (mem_req && !mem_burst));

   p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);
endmodule

bind rac_cache rac_cache_chk #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_q(en_q),
   .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
   .req_cacheable(req_cacheable), .req_lock(req_lock),
   .hit(hit), .ins_en(ins_en), .resp_valid(resp_valid),
   .mem_req(mem_req), .mem_write(mem_write), .mem_burst(mem_burst),
   .mem_lock(mem_lock), .mem_addr(mem_addr)
);

// File: tb/rac_cache_test.sv
module rac_cache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cache_en = 1'b0, flush = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_cacheable = 1'b0, req_lock = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        req_ready, resp_valid;
   logic [31:0] resp_rdata;
   logic        mem_req, mem_write, mem_burst, mem_lock;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_rvalid, mem_ack;
   logic [31:0] mem_rdata;

   always #5 clk = ~clk;

   rac_cache uut (
      .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
      .req_valid(req_valid), .req_write(req_write), .req_cacheable(req_cacheable),
      .req_lock(req_lock), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .mem_req(mem_req), .mem_write(mem_write), .mem_burst(mem_burst), .mem_lock(mem_lock),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // Memory model: word at byte address a starts as 32'hC0DE0000 | a[15:0].
   logic [31:0] bmem [4096];
   logic        p_busy, p_wait, p_wr;
   logic [31:0] p_base;
   logic [2:0]  p_left;
   logic [11:0] p_idx;
   int          ext_cnt = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_busy <= 1'b0; p_wait <= 1'b0; p_wr <= 1'b0; p_left <= '0;
         p_base <= '0; p_idx <= '0;
         mem_rvalid <= 1'b0; mem_ack <= 1'b0; mem_rdata <= '0;
      end else begin
         mem_rvalid <= 1'b0;
         mem_ack    <= 1'b0;
         if (mem_req) begin
            ext_cnt <= ext_cnt + 1;
            p_busy  <= 1'b1;
            p_wait  <= 1'b1;
            p_wr    <= mem_write;
            p_base  <= mem_addr;
            p_idx   <= mem_addr[13:2];
            p_left  <= mem_write ? 3'd1 : (mem_burst ? 3'd4 : 3'd1);
            if (mem_write) bmem[mem_addr[13:2]] <= mem_wdata;
         end else if (p_busy) begin
            if (p_wait) p_wait <= 1'b0;
            else begin
               if (p_wr) mem_ack <= 1'b1;
               else begin
                  mem_rvalid <= 1'b1;
                  mem_rdata  <= bmem[p_idx];
               end
               p_idx  <= p_idx + 1'b1;
               p_left <= p_left - 1'b1;
               if (p_left == 3'd1) p_busy <= 1'b0;
            end
         end
      end
   end

   int  n_checks = 0, n_errors = 0;
   bit  finished = 1'b0;

   function automatic string rname(input int id);
      case (id)
         1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
         5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
         9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
         default: return "R?";
      endcase
   endfunction

   task automatic check(input bit ok, input int id, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", rname(id), what, act, exp);
      end
   endtask

   logic [31:0] got_data;
   logic        got_ready, got_lock;
   int          got_ext;

   task automatic access(input logic wr, input logic cach, input logic lk,
                         input logic [31:0] addr, input logic [31:0] wd);
      int start;
      int waited;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      start = ext_cnt;
      req_valid = 1'b1; req_write = wr; req_cacheable = cach; req_lock = lk;
      req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      waited = 0;
      while (!resp_valid && waited < 200) begin
         @(negedge clk);
         waited++;
      end
      got_data  = resp_rdata;
      got_ready = req_ready;
      got_lock  = mem_lock;
      got_ext   = ext_cnt - start;
      if (!resp_valid) check(1'b0, 12, "no response", 32'd0, 32'd1);
   endtask

   // Vector fields: wr, cacheable, lock, addr, wdata, expected data, expected memory transactions, requirement
   localparam int NV = 14;
   localparam logic [104:0] VEC [NV] = '{
      {1'b0, 1'b1, 1'b0, 32'h0000_0104, 32'h0,          32'hC0DE_0104, 2'd1, 4'd3},
      {1'b0, 1'b1, 1'b0, 32'h0000_0108, 32'h0,          32'hC0DE_0108, 2'd0, 4'd2},
      {1'b0, 1'b0, 1'b0, 32'h0000_2000, 32'h0,          32'hC0DE_2000, 2'd1, 4'd4},
      {1'b0, 1'b0, 1'b0, 32'h0000_2000, 32'h0,          32'hC0DE_2000, 2'd1, 4'd4},
      {1'b0, 1'b0, 1'b0, 32'h0000_010C, 32'h0,          32'hC0DE_010C, 2'd0, 4'd5},
      {1'b1, 1'b1, 1'b0, 32'h0000_010C, 32'hDEAD_BEEF,  32'h0,         2'd1, 4'd7},
      {1'b0, 1'b1, 1'b0, 32'h0000_010C, 32'h0,          32'hDEAD_BEEF, 2'd0, 4'd7},
      {1'b1, 1'b1, 1'b0, 32'h0000_3000, 32'h1234_5678,  32'h0,         2'd1, 4'd7},
      {1'b0, 1'b0, 1'b0, 32'h0000_3000, 32'h0,          32'h1234_5678, 2'd1, 4'd7},
      {1'b0, 1'b1, 1'b1, 32'h0000_0104, 32'h0,          32'hC0DE_0104, 2'd1, 4'd6},
      {1'b1, 1'b1, 1'b1, 32'h0000_0104, 32'h5555_AAAA,  32'h0,         2'd1, 4'd6},
      {1'b0, 1'b1, 1'b0, 32'h0000_0104, 32'h0,          32'h5555_AAAA, 2'd0, 4'd6},
      {1'b0, 1'b1, 1'b0, 32'h0000_020C, 32'h0,          32'hC0DE_020C, 2'd1, 4'd8},
      {1'b0, 1'b1, 1'b0, 32'h0000_0200, 32'h0,          32'hC0DE_0200, 2'd0, 4'd1}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         check(1'b0, 12, "watchdog expired", 32'd0, 32'd1);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : main
      int misses;
      for (int i = 0; i < 4096; i++) bmem[i] = 32'hC0DE_0000 | (i << 2);
      repeat (3) @(negedge clk);
      // R9: state during reset
      check(req_ready == 1'b1 && resp_valid == 1'b0 && mem_req == 1'b0 && mem_lock == 1'b0,
            9, "reset outputs", {28'd0, req_ready, resp_valid, mem_req, mem_lock}, 32'h8);
      rst_n = 1'b1;
      cache_en = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         logic [104:0] e;
         e = VEC[v];
         access(e[104], e[103], e[102], e[101:70], e[69:38]);
         check(got_ext == int'(e[5:4]), int'(e[3:0]), "memory transactions",
               32'(got_ext), 32'(e[5:4]));
         if (!e[104]) check(got_data == e[37:6], int'(e[3:0]), "read data", got_data, e[37:6]);
         if (e[102] && !e[104]) check(got_lock == 1'b1, 6, "lock held after locked read",
                                      32'(got_lock), 32'd1);
         if (e[102] && e[104]) check(got_lock == 1'b0, 6, "lock dropped after write",
                                     32'(got_lock), 32'd0);
      end

      // R8: word 0 of a new line is returned while the fill is still running
      access(1'b0, 1'b1, 1'b0, 32'h0000_0400, 32'h0);
      check(got_data == 32'hC0DE_0400, 8, "early word data", got_data, 32'hC0DE_0400);
      check(got_ready == 1'b0, 8, "fill still busy at early word", 32'(got_ready), 32'd0);

      // R9: flush invalidates a present line
      @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
      access(1'b0, 1'b1, 1'b0, 32'h0000_0108, 32'h0);
      check(got_ext == 1, 9, "miss after flush", 32'(got_ext), 32'd1);

      // R10: disabled cache goes external and leaves lines alone
      cache_en = 1'b0; repeat (2) @(negedge clk);
      access(1'b0, 1'b1, 1'b0, 32'h0000_0108, 32'h0);
      check(got_ext == 1, 10, "disabled read external", 32'(got_ext), 32'd1);
      access(1'b1, 1'b1, 1'b0, 32'h0000_0108, 32'h7777_0000);
      check(got_ext == 1, 10, "disabled write external", 32'(got_ext), 32'd1);
      cache_en = 1'b1; repeat (2) @(negedge clk);
      access(1'b0, 1'b1, 1'b0, 32'h0000_0108, 32'h0);
      check(got_ext == 0 && got_data == 32'hC0DE_0108, 10, "line untouched while disabled",
            got_data, 32'hC0DE_0108);

      // R11: five tags into one set; the newest hits, some older one was displaced
      for (int k = 0; k < 5; k++) begin
         access(1'b0, 1'b1, 1'b0, 32'h0000_0300 + 32'(k) * 32'h400, 32'h0);
         check(got_ext == 1, 11, "conflict fill", 32'(got_ext), 32'd1);
      end
      access(1'b0, 1'b1, 1'b0, 32'h0000_1300, 32'h0);
      check(got_ext == 0, 11, "newest line hits", 32'(got_ext), 32'd0);
      misses = 0;
      for (int k = 0; k < 4; k++) begin
         access(1'b0, 1'b1, 1'b0, 32'h0000_0300 + 32'(k) * 32'h400, 32'h0);
         misses += got_ext;
      end
      check(misses >= 1, 11, "some older line evicted", 32'(misses), 32'd1);

      // R9: reset clears lines and forces the cache disabled
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check(req_ready == 1'b1 && resp_valid == 1'b0 && mem_req == 1'b0 && mem_lock == 1'b0,
            9, "outputs in second reset", {28'd0, req_ready, resp_valid, mem_req, mem_lock}, 32'h8);
      rst_n = 1'b1; repeat (2) @(negedge clk);
      access(1'b0, 1'b1, 1'b0, 32'h0000_1300, 32'h0);
      check(got_ext == 1, 9, "miss after reset", 32'(got_ext), 32'd1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule